// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An eight-pin general-purpose I/O port driven through a small register interface. Every pin has a direction bit and an output bit. Both the direction register and the output register have three extra write addresses: one sets bits, one clears bits and one toggles bits. A write through any of these affects only the pins whose data bits are 1, so software can change one pin without touching its neighbours. Each pin also has a configuration byte. This byte selects the drive style (push-pull, open-drain in either polarity, or bus-keeper) and an optional pull, turns on an inversion of the pin's input and output, and chooses how the pin's input is sensed for the interrupt. A pin mask lets a single configuration write reach several pins at once.

Pad inputs are resynchronised by two flip-flops. They are then inverted where a pin asks for it and offered both as a readable input value and to a per-pin edge/level detector. The detector sets a sticky flag, and each flag is cleared by writing 1 to it. The interrupt line is high while any flag with its mask bit set is high. Two control bits replace the output value of a fixed pin: one routes an event input to the highest pin, the other routes a clock input to the pin chosen by a parameter. The pad itself lies outside the block. The controller presents a drive enable, a drive value and pull-up/pull-down requests for each pin.

The design has no sequencer with named states. Its sequential state is the register file, the two-stage synchroniser, and for each pin a previous-level flop and a flag flop.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, direction, output, interrupt mask, pin mask, control, flags and all pin configurations read 0. No pad is driven, no pull is requested and `irq` is low.
- R2: Register map for reads and plain writes, with 5-bit addresses: 0 direction, 4 output, 8 input (read only), 9 flags, 10 interrupt mask, 11 pin mask, 13 control (bit 0 routes the event to the top pin, bit 1 routes the clock to the clock pin), and 16+i for pin i's configuration. Reading 1–3 returns direction and reading 5–7 returns output. A write takes effect at the clock edge that samples it.
- R3: Writes to address 1/2/3 set/clear/toggle the direction bits where the data bit is 1. Writes to 5/6/7 do the same for the output bits. Bits whose data bit is 0 keep their value.
- R4: A write to address 12 stores the same configuration in every pin whose pin-mask bit is 1 and leaves the other pins' configurations unchanged. Configuration fields: [2:0] drive mode, [3] invert, [5:4] sense mode. Bits [7:6] are stored as 0.
- R5: Drive modes 0 push-pull, 1 bus-keeper, 2 push-pull with pull-down, 3 push-pull with pull-up, 4 drive-high-only, 5 drive-low-only, 6 drive-high-only with pull-down, 7 drive-low-only with pull-up. An input pin is never driven. An output pin in modes 0–3 is always driven. In modes 4/6 it is driven only while its pad value is 1, and in modes 5/7 only while its pad value is 0.
- R6: A pull is requested only while the pin is not driven. Modes 3/7 request a pull-up and modes 2/6 a pull-down. Mode 1 pulls toward the last synchronised raw pad level. Pull-up and pull-down are never both requested.
- R7: `pad_out` always carries the pin's output value XOR its invert bit. The input value of a pin is also XORed with its invert bit.
- R8: With control bit 0 set, pin 7's output value is `evt_ch0` instead of its output bit. With control bit 1 set, pin `CLK_PIN`'s output value is `clk_src`. The event takes precedence if both select the same pin.
- R9: A change on `pad_in` appears in the input register after the second rising clock edge.
- R10: Sense modes: 0 both edges, 1 rising, 2 falling, 3 low level, all evaluated on the inverted synchronised input. A detected event sets the pin's flag one edge after it shows in the input register.
- R11: Writing 1 to a flag bit clears it unless an event sets it at the same edge, in which case the set wins.
- R12: `irq` is high exactly when some flag bit and the matching interrupt-mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pad_in | input | NPIN | Raw pad levels |
| evt_ch0 | input | 1 | Event level that can be routed to pin 7 |
| clk_src | input | 1 | Clock that can be routed to pin CLK_PIN |
| pad_oe | output | NPIN | Pad drive enables |
| pad_out | output | NPIN | Pad drive values |
| pad_pu | output | NPIN | Pull-up requests |
| pad_pd | output | NPIN | Pull-down requests |
| irq | output | 1 | Port interrupt |

## Verification
The bench builds the port with NPIN = 8 and CLK_PIN = 2. This places the clock override on a pin other than the event pin, so both overrides and their combination can be observed separately. With the full eight pins, all eight drive modes, the four sense modes and the inversion can be held by different pins at the same time. A behavioural model is compared with every output and with the addressed read value on every cycle, during directed phases and during a long phase of random writes and pad changes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DW = 8;
    localparam int AW = 5;

    typedef enum logic [2:0] {
        DRV_PUSH     = 3'd0,
        DRV_KEEPER   = 3'd1,
        DRV_PUSH_PD  = 3'd2,
        DRV_PUSH_PU  = 3'd3,
        DRV_HI_ONLY  = 3'd4,
        DRV_LO_ONLY  = 3'd5,
        DRV_HI_PD    = 3'd6,
        DRV_LO_PU    = 3'd7
    } drive_mode_e;

    typedef enum logic [1:0] {
        SNS_ANY  = 2'd0,
        SNS_RISE = 2'd1,
        SNS_FALL = 2'd2,
        SNS_LOW  = 2'd3
    } sense_mode_e;

    typedef struct packed {
        logic [1:0]  spare;
        sense_mode_e sense;
        logic        invert;
        drive_mode_e drive;
    } pin_cfg_t;

    localparam logic [AW-1:0] A_DIR      = 5'd0;
    localparam logic [AW-1:0] A_DIR_SET  = 5'd1;
    localparam logic [AW-1:0] A_DIR_CLR  = 5'd2;
    localparam logic [AW-1:0] A_DIR_TGL  = 5'd3;
    localparam logic [AW-1:0] A_OUT      = 5'd4;
    localparam logic [AW-1:0] A_OUT_SET  = 5'd5;
    localparam logic [AW-1:0] A_OUT_CLR  = 5'd6;
    localparam logic [AW-1:0] A_OUT_TGL  = 5'd7;
    localparam logic [AW-1:0] A_IN       = 5'd8;
    localparam logic [AW-1:0] A_FLAG     = 5'd9;
    localparam logic [AW-1:0] A_IMASK    = 5'd10;
    localparam logic [AW-1:0] A_PMASK    = 5'd11;
    localparam logic [AW-1:0] A_CFG_ALL  = 5'd12;
    localparam logic [AW-1:0] A_CTRL     = 5'd13;
    localparam int            CFG_BASE   = 16;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_port_pkg::*;
(
    input  logic        dir,
    input  logic        val,
    input  logic        invert,
    input  drive_mode_e mode,
    input  logic        keep_lvl,
    output logic        oe,
    output logic        o,
    output logic        pu,
    output logic        pd
);
    logic want_pu;
    logic want_pd;

    always_comb begin
        o       = val ^ invert;
        oe      = 1'b0;
        want_pu = 1'b0;
        want_pd = 1'b0;
        unique case (mode)
            DRV_PUSH:    oe = dir;
            DRV_KEEPER: begin
                oe      = dir;
                want_pu = keep_lvl;
                want_pd = ~keep_lvl;
            end
            DRV_PUSH_PD: begin
                oe      = dir;
                want_pd = 1'b1;
            end
            DRV_PUSH_PU: begin
                oe      = dir;
                want_pu = 1'b1;
            end
            DRV_HI_ONLY: oe = dir & o;
            DRV_LO_ONLY: oe = dir & ~o;
            DRV_HI_PD: begin
                oe      = dir & o;
                want_pd = 1'b1;
            end
            DRV_LO_PU: begin
                oe      = dir & ~o;
                want_pu = 1'b1;
            end
            default: oe = 1'b0;
        endcase
        pu = want_pu & ~oe;
        pd = want_pd & ~oe;
    end
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
    import gpio_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lvl,
    input  sense_mode_e mode,
    input  logic        clr,
    output logic        flag
);
    logic prev_q;
    logic hit;

    always_comb begin
        unique case (mode)
            SNS_ANY:  hit = lvl ^ prev_q;
            SNS_RISE: hit = lvl & ~prev_q;
            SNS_FALL: hit = ~lvl & prev_q;
            SNS_LOW:  hit = ~lvl;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            prev_q <= lvl;
            flag   <= hit | (flag & ~clr);
        end
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPIN    = 8,
    parameter int CLK_PIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [NPIN-1:0] pad_in,
    input  logic            evt_ch0,
    input  logic            clk_src,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] pad_pd,
    output logic            irq
);
    localparam int EVT_PIN = NPIN - 1;

    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] out_q;
    logic [NPIN-1:0] imask_q;
    logic [NPIN-1:0] pmask_q;
    logic [1:0]      ctrl_q;
    pin_cfg_t        cfg_q [NPIN];

    logic [NPIN-1:0] raw_sync;
    logic [NPIN-1:0] in_val;
    logic [NPIN-1:0] inv_vec;
    logic [NPIN-1:0] out_val;
    logic [NPIN-1:0] flag_vec;
    logic [NPIN-1:0] flag_clr;
    logic [NPIN-1:0] wd;
    pin_cfg_t        cfg_wr;

    assign wd     = wr_data[NPIN-1:0];
    assign cfg_wr = pin_cfg_t'({2'b00, wr_data[5:0]});

    // control and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            out_q   <= '0;
            imask_q <= '0;
            pmask_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_DIR:     dir_q   <= wd;
                A_DIR_SET: dir_q   <= dir_q | wd;
                A_DIR_CLR: dir_q   <= dir_q & ~wd;
                A_DIR_TGL: dir_q   <= dir_q ^ wd;
                A_OUT:     out_q   <= wd;
                A_OUT_SET: out_q   <= out_q | wd;
                A_OUT_CLR: out_q   <= out_q & ~wd;
                A_OUT_TGL: out_q   <= out_q ^ wd;
                A_IMASK:   imask_q <= wd;
                A_PMASK:   pmask_q <= wd;
                A_CTRL:    ctrl_q  <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    // per-pin configuration
    for (genvar p = 0; p < NPIN; p++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[p] <= '0;
            end else if (wr_en) begin
                if (wr_addr == AW'(CFG_BASE + p))
                    cfg_q[p] <= cfg_wr;
                else if (wr_addr == A_CFG_ALL && pmask_q[p])
                    cfg_q[p] <= cfg_wr;
            end
        end
        assign inv_vec[p] = cfg_q[p].invert;
    end

    assign flag_clr = (wr_en && wr_addr == A_FLAG) ? wd : '0;

    gpio_in_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (raw_sync)
    );

    assign in_val = raw_sync ^ inv_vec;

    // output value selection with fixed-pin overrides
    always_comb begin
        out_val = out_q;
        if (ctrl_q[1]) out_val[CLK_PIN] = clk_src;
        if (ctrl_q[0]) out_val[EVT_PIN] = evt_ch0;
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        gpio_pin_drive u_drv (
            .dir      (dir_q[p]),
            .val      (out_val[p]),
            .invert   (cfg_q[p].invert),
            .mode     (cfg_q[p].drive),
            .keep_lvl (raw_sync[p]),
            .oe       (pad_oe[p]),
            .o        (pad_out[p]),
            .pu       (pad_pu[p]),
            .pd       (pad_pd[p])
        );

        gpio_pin_sense u_sns (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (in_val[p]),
            .mode  (cfg_q[p].sense),
            .clr   (flag_clr[p]),
            .flag  (flag_vec[p])
        );

        // R5
        lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe[p] && (cfg_q[p].drive == DRV_LO_ONLY || cfg_q[p].drive == DRV_LO_PU))
            |-> !pad_out[p]);
        // R6
        pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[p] && pad_pd[p]) && !(pad_oe[p] && (pad_pu[p] || pad_pd[p])));
    end

    assign irq = |(flag_vec & imask_q);

    // read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DIR, A_DIR_SET, A_DIR_CLR, A_DIR_TGL: rd_data[NPIN-1:0] = dir_q;
            A_OUT, A_OUT_SET, A_OUT_CLR, A_OUT_TGL: rd_data[NPIN-1:0] = out_q;
            A_IN:    rd_data[NPIN-1:0] = in_val;
            A_FLAG:  rd_data[NPIN-1:0] = flag_vec;
            A_IMASK: rd_data[NPIN-1:0] = imask_q;
            A_PMASK: rd_data[NPIN-1:0] = pmask_q;
            A_CTRL:  rd_data[1:0]      = ctrl_q;
            default: ;
        endcase
        for (int p = 0; p < NPIN; p++)
            if (rd_addr == AW'(CFG_BASE + p)) rd_data = cfg_q[p];
    end

    // R3
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIR_SET) |=> dir_q == ($past(dir_q) | $past(wd)));
    // R3
    out_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OUT_TGL) |=> out_q == ($past(out_q) ^ $past(wd)));
    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q == '0) |-> !irq);
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
    localparam int NPIN = 8;
    localparam int CLKP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] pad_in = '0;
    logic       evt_ch0 = 1'b0;
    logic       clk_src = 1'b0;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_pd;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_port_ctrl #(.NPIN(NPIN), .CLK_PIN(CLKP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .evt_ch0(evt_ch0), .clk_src(clk_src),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .irq(irq)
    );

    // behavioural reference state
    bit [7:0] m_dir, m_out, m_imask, m_pmask, m_flag, m_prev, m_s1, m_s2;
    bit [1:0] m_ctrl;
    bit [7:0] m_cfg [8];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_imask = 0; m_pmask = 0; m_flag = 0;
            m_prev = 0; m_s1 = 0; m_s2 = 0; m_ctrl = 0;
            for (int i = 0; i < 8; i++) m_cfg[i] = 0;
        end else begin
            bit [7:0] nflag, nprev, clr, d;
            d = wr_data;
            clr = (wr_en && wr_addr == 9) ? d : 8'h00;
            for (int i = 0; i < 8; i++) begin
                bit lv, pv, ev;
                lv = m_s2[i] ^ m_cfg[i][3];
                pv = m_prev[i];
                case (m_cfg[i][5:4])
                    0: ev = (lv != pv);
                    1: ev = lv && !pv;
                    2: ev = !lv && pv;
                    default: ev = !lv;
                endcase
                nflag[i] = ev || (m_flag[i] && !clr[i]);
                nprev[i] = lv;
            end
            m_flag = nflag;
            m_prev = nprev;
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (wr_en) begin
                if (wr_addr == 0) m_dir = d;
                if (wr_addr == 1) m_dir = m_dir | d;
                if (wr_addr == 2) m_dir = m_dir & ~d;
                if (wr_addr == 3) m_dir = m_dir ^ d;
                if (wr_addr == 4) m_out = d;
                if (wr_addr == 5) m_out = m_out | d;
                if (wr_addr == 6) m_out = m_out & ~d;
                if (wr_addr == 7) m_out = m_out ^ d;
                if (wr_addr == 10) m_imask = d;
                if (wr_addr == 13) m_ctrl = d[1:0];
                if (wr_addr == 12)
                    for (int i = 0; i < 8; i++) if (m_pmask[i]) m_cfg[i] = d & 8'h3F;
                if (wr_addr >= 16 && wr_addr < 24) m_cfg[wr_addr - 16] = d & 8'h3F;
                if (wr_addr == 11) m_pmask = d;
            end
        end
    end

    function automatic bit [7:0] m_read(bit [4:0] a);
        bit [7:0] inv;
        for (int i = 0; i < 8; i++) inv[i] = m_cfg[i][3];
        case (a)
            0, 1, 2, 3: return m_dir;
            4, 5, 6, 7: return m_out;
            8:  return m_s2 ^ inv;
            9:  return m_flag;
            10: return m_imask;
            11: return m_pmask;
            13: return {6'd0, m_ctrl};
            default: return (a >= 16 && a < 24) ? m_cfg[a - 16] : 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [7:0] e_oe, e_o, e_pu, e_pd;
            for (int i = 0; i < 8; i++) begin
                bit v, o, en;
                int md;
                md = m_cfg[i][2:0];
                v = m_out[i];
                if (m_ctrl[1] && i == CLKP) v = clk_src;
                if (m_ctrl[0] && i == 7) v = evt_ch0;
                o = v ^ m_cfg[i][3];
                if (md < 4) en = m_dir[i];
                else if (md == 4 || md == 6) en = m_dir[i] && o;
                else en = m_dir[i] && !o;
                e_oe[i] = en; e_o[i] = o; e_pu[i] = 0; e_pd[i] = 0;
                if (!en) begin
                    if (md == 3 || md == 7) e_pu[i] = 1;
                    if (md == 2 || md == 6) e_pd[i] = 1;
                    if (md == 1) begin e_pu[i] = m_s2[i]; e_pd[i] = !m_s2[i]; end
                end
            end
            chk("R5 pad_oe", pad_oe, e_oe);
            chk("R7 pad_out", pad_out, e_o);
            chk("R6 pad_pu", pad_pu, e_pu);
            chk("R6 pad_pd", pad_pd, e_pd);
            chk("R12 irq", {7'd0, irq}, {7'd0, |(m_flag & m_imask)});
            chk("R2 rd_data", rd_data, m_read(rd_addr));
        end
    end

    task automatic wr(bit [4:0] a, bit [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(string tag, bit [4:0] a, bit [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pulls", pad_pu | pad_pd, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd_chk("R1 dir", 0, 8'h00);
        rd_chk("R1 cfg3", 19, 8'h00);

        // R3 set/clear/toggle aliases
        wr(0, 8'h0F);
        wr(1, 8'h30);  rd_chk("R3 dir set", 0, 8'h3F);
        wr(2, 8'h05);  rd_chk("R3 dir clr", 2, 8'h3A);
        wr(3, 8'hFF);  rd_chk("R3 dir tgl", 0, 8'hC5);
        wr(5, 8'h81);  rd_chk("R3 out set", 4, 8'h81);
        wr(7, 8'h03);  rd_chk("R3 out tgl", 4, 8'h82);

        // R4 multi-pin configuration
        wr(11, 8'h81);
        wr(12, 8'hC5);
        rd_chk("R4 cfg0", 16, 8'h05);
        rd_chk("R4 cfg7", 23, 8'h05);
        rd_chk("R4 cfg1 untouched", 17, 8'h00);

        // R5 drive-low-only pin 7 with value 1 released, pin 0 value 0 driven
        wr(0, 8'h81);
        chk("R5 lo-only released", {6'd0, pad_oe[7], pad_oe[0]}, 8'h01);

        // R7 inversion on pin 1 (push-pull, invert)
        wr(17, 8'h08);
        wr(1, 8'h02);
        wr(6, 8'h02);
        chk("R7 inverted out", {7'd0, pad_out[1]}, 8'h01);

        // R8 overrides
        wr(23, 8'h00);
        wr(16 + CLKP, 8'h00);
        wr(1, 8'h84);
        wr(6, 8'h84);
        evt_ch0 = 1; clk_src = 1;
        wr(13, 8'h03);
        chk("R8 event on pin 7", {7'd0, pad_out[7]}, 8'h01);
        chk("R8 clock on pin", {7'd0, pad_out[CLKP]}, 8'h01);
        wr(13, 8'h00);
        chk("R8 override off", {7'd0, pad_out[7]}, 8'h00);

        // R9 synchroniser latency, R10 rising sense, R12 irq
        wr(19, 8'h10);
        wr(10, 8'h08);
        wr(9, 8'hFF);
        pad_in[3] = 1;
        rd_addr = 8;
        @(negedge clk);
        chk("R9 in after one edge", rd_data & 8'h08, 8'h00);
        @(negedge clk);
        chk("R9 in after two edges", rd_data & 8'h08, 8'h08);
        @(negedge clk);
        rd_chk("R10 rise flag", 9, m_flag | 8'h08);
        chk("R12 irq high", {7'd0, irq}, 8'h01);

        // R11 write-one-to-clear
        wr(9, 8'h08);
        rd_chk("R11 cleared", 9, m_flag & 8'hF7);
        chk("R11 irq low", {7'd0, irq}, 8'h00);

        // R10 low-level sense re-sets despite clear
        wr(19, 8'h30);
        pad_in[3] = 0;
        repeat (3) @(negedge clk);
        wr(9, 8'h08);
        rd_chk("R11 set wins at level", 9, m_flag | 8'h08);

        // random phase, every cycle checked against the model
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 9);
            rd_addr = 5'($urandom_range(0, 23));
            if (r < 4) begin
                wr(5'($urandom_range(0, 23)), 8'($urandom));
            end else if (r < 7) begin
                pad_in = 8'($urandom);
                @(negedge clk);
            end else begin
                evt_ch0 = 1'($urandom); clk_src = 1'($urandom);
                @(negedge clk);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule